// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block resizes one line of 8-bit samples from a programmed input width to a programmed output width. It filters with a 32-phase, 8-tap FIR whose taps come from a loadable table. A line enters on a valid/ready stream whose first sample carries a start-of-line flag. The block buffers the whole line. It then derives a 16.16 fixed-point step by sequential division and emits the resampled line on a second valid/ready stream. A last flag marks the final output sample.

Control is a four-state machine. ST_IDLE waits for a start-of-line sample and drops any sample that lacks the flag. The start transition goes to ST_FILL, or straight to ST_DIV when the input width is one. ST_FILL stores samples, and the fill-complete transition goes to ST_DIV. ST_DIV runs the step division, and the quotient-ready transition goes to ST_EMIT. ST_EMIT produces one output per accepted handshake, and the line-done transition returns to ST_IDLE after the last output is taken.

Coefficient words are first written to a staging table. They take effect only when a commit bit is written. Configuration writes are refused while a line is in flight.

Top module: `hscale_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Both widths are MAX_W (64). Every phase of the live table is the identity, so with equal widths each output equals the input sample at the same index.
- R2: Phase p uses word address 2p for taps 0..3 and word address 2p+1 for taps 4..7. Tap k sits in bits [8(k mod 4)+7 : 8(k mod 4)] and is two's complement. Tap k multiplies the source sample at index floor(pos)+k-3.
- R3: The step is floor(in_w*65536/out_w). Output j is taken at pos = j*step, with integer index pos>>16 and phase pos[15:11].
- R4: The 8 products are summed as signed values. The sum has 32 added, is shifted right arithmetically by 6, and is clamped to 0..255.
- R5: A source index below 0 uses sample 0, and an index above in_w-1 uses sample in_w-1.
- R6: Writes to addresses 0..63 change only the staging table. Writing address 66 with bit 0 set copies the staging table into the live table. Until then, filtering uses the previous live table.
- R7: Address 64 sets the input width and address 65 sets the output width. Only values 1..MAX_W are accepted; other values leave the width unchanged.
- R8: In ST_IDLE, samples without in_sol are consumed and discarded. A sample with in_sol starts a line. Exactly in_w samples are accepted, and in_ready then stays low until the line's outputs are done.
- R9: Each line yields exactly out_w outputs, and out_last is 1 on the final one only.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R11: Configuration writes are ignored from the cycle a start-of-line sample is offered in ST_IDLE until the last output is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted |
| in_sol | input | 1 | Input sample is the first of a line |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 8 | Scaled output sample |
| out_last | output | 1 | Output sample is last of the line |

## Verification
Several properties are checked on every cycle:
- output hold under back-pressure;
- exclusion between the two streams;
- out_last only with out_valid;
- the integer source index staying below the input width;
- widths and the live table holding still outside their permitted updates;
- the divider's start and done pulses.

Only the bench scenarios can show the rest. These are the numerical result of the filter with its rounding and clamping, edge replication, the staging/commit split, rejection of bad or mid-line writes, and the exact per-line output count. The bench shows them by sweeping many width pairs and sample patterns against an arithmetic model.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DIV,
        ST_EMIT
    } hs_state_t;
endpackage

// File: rtl/hs_div.sv
module hs_div #(
    parameter int NUM_W = 23,
    parameter int DEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quot,
    output logic             done
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] q;
    logic [CW-1:0]    cnt;
    logic             busy;
    logic [DEN_W:0]   trial;

    assign trial = {rem, q[NUM_W-1]};
    assign quot  = q;

    // restoring division, one quotient bit per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            q    <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                q    <= num;
                cnt  <= CW'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den}) begin
                    rem <= DEN_W'(trial - {1'b0, den});
                    q   <= {q[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= trial[DEN_W-1:0];
                    q   <= {q[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done)); // R3
    AST_DIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
endmodule

// File: rtl/hs_coef_bank.sv
module hs_coef_bank #(
    parameter int PHASES  = 32,
    parameter int TAPS    = 8,
    parameter int TAP_W   = 8,
    parameter int NORM_SH = 6,
    localparam int WPP    = (TAPS * TAP_W) / 32,
    localparam int WORDS  = PHASES * WPP,
    localparam int WI_W   = $clog2(WORDS),
    localparam int PH_W   = $clog2(PHASES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WI_W-1:0]         wr_idx,
    input  logic [31:0]             wr_word,
    input  logic                    commit,
    input  logic [PH_W-1:0]         rd_phase,
    output logic [TAPS*TAP_W-1:0]   rd_taps
);
    localparam int CENTER = TAPS / 2 - 1;
    localparam logic [TAPS*TAP_W-1:0] IDENT =
        (TAPS*TAP_W)'(1 << NORM_SH) << (TAP_W * CENTER);

    logic [31:0] stage_m [WORDS];
    logic [31:0] live_m  [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [31:0] RST_WORD = IDENT[(g % WPP)*32 +: 32];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_m[g] <= RST_WORD;
                live_m[g]  <= RST_WORD;
            end else begin
                if (wr_en && (wr_idx == WI_W'(g)))
                    stage_m[g] <= wr_word;
                if (commit)
                    live_m[g] <= stage_m[g];
            end
        end

        AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(live_m[g])); // R6
    end

    always_comb begin
        for (int w = 0; w < WPP; w++)
            rd_taps[w*32 +: 32] = live_m[int'(rd_phase) * WPP + w];
    end
endmodule

// File: rtl/hs_fir.sv
module hs_fir #(
    parameter int PIX_W   = 8,
    parameter int MAX_W   = 64,
    parameter int TAPS    = 8,
    parameter int TAP_W   = 8,
    parameter int NORM_SH = 6,
    parameter int BASE_W  = 8,
    localparam int WW     = $clog2(MAX_W + 1)
) (
    input  logic [MAX_W*PIX_W-1:0] line_vec,
    input  logic [WW-1:0]          in_w,
    input  logic [BASE_W-1:0]      base,
    input  logic [TAPS*TAP_W-1:0]  taps,
    output logic [PIX_W-1:0]       pix
);
    localparam int CENTER = TAPS / 2 - 1;
    localparam int SUM_W  = PIX_W + TAP_W + $clog2(TAPS) + 1;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] rnd;
    logic signed [SUM_W-1:0] shr;

    always_comb begin
        sum = '0;
        for (int k = 0; k < TAPS; k++) begin
            int p;
            logic [PIX_W-1:0] smp;
            logic signed [TAP_W-1:0] tp;
            p = int'(base) + k - CENTER;
            if (p < 0)
                p = 0;
            if (p > int'(in_w) - 1)
                p = int'(in_w) - 1;
            smp = line_vec[p*PIX_W +: PIX_W];
            tp  = taps[k*TAP_W +: TAP_W];
            sum = sum + SUM_W'($signed({1'b0, smp}) * tp);
        end
        rnd = sum + SUM_W'(1 << (NORM_SH - 1));
        shr = rnd >>> NORM_SH;
        if (shr < 0)
            pix = '0;
        else if (shr > SUM_W'(PIX_MAX))
            pix = PIX_W'(PIX_MAX);
        else
            pix = shr[PIX_W-1:0];
    end
endmodule

// File: rtl/hscale_top.sv
module hscale_top #(
    parameter int PIX_W   = 8,
    parameter int MAX_W   = 64,
    parameter int PHASES  = 32,
    parameter int TAPS    = 8,
    parameter int TAP_W   = 8,
    parameter int NORM_SH = 6,
    parameter int FRAC_W  = 16,
    localparam int CFG_AW = $clog2(PHASES * TAPS * TAP_W / 32) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_last
);
    import hs_pkg::*;

    localparam int WW        = $clog2(MAX_W + 1);
    localparam int IDX_W     = $clog2(MAX_W);
    localparam int PH_W      = $clog2(PHASES);
    localparam int WORDS     = PHASES * (TAPS * TAP_W / 32);
    localparam int WI_W      = $clog2(WORDS);
    localparam int ADDR_IN   = WORDS;
    localparam int ADDR_OUT  = WORDS + 1;
    localparam int ADDR_CTRL = WORDS + 2;
    localparam int NUM_W     = WW + FRAC_W;
    localparam int ACC_W     = NUM_W + 1;
    localparam int BASE_W    = ACC_W - FRAC_W;

    hs_state_t state, nxt;

    logic [WW-1:0]    in_w_r, out_w_r;
    logic [WW-1:0]    fill_cnt;
    logic [WW-1:0]    ocnt;
    logic [ACC_W-1:0] acc;
    logic [NUM_W-1:0] step;
    logic             div_start, div_done;
    logic [PIX_W-1:0] lbuf [MAX_W];
    logic [MAX_W*PIX_W-1:0] line_vec;
    logic [TAPS*TAP_W-1:0]  taps;
    logic [PH_W-1:0]  phase;
    logic [BASE_W-1:0] base;

    // ---------------- configuration decode ----------------
    logic line_busy, cfg_ok, width_ok, coef_we, commit;

    assign line_busy = (state != ST_IDLE) || (in_valid && in_sol);
    assign cfg_ok    = cfg_we && !line_busy;
    assign width_ok  = (cfg_wdata != 32'd0) && (cfg_wdata <= 32'(MAX_W));
    assign coef_we   = cfg_ok && (cfg_addr < CFG_AW'(WORDS));
    assign commit    = cfg_ok && (cfg_addr == CFG_AW'(ADDR_CTRL)) && cfg_wdata[0];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (in_valid && in_sol)
                    nxt = (in_w_r == WW'(1)) ? ST_DIV : ST_FILL;
            ST_FILL:
                if (in_valid && (fill_cnt == in_w_r - WW'(1)))
                    nxt = ST_DIV;
            ST_DIV:
                if (div_done)
                    nxt = ST_EMIT;
            ST_EMIT:
                if (out_ready && (ocnt == out_w_r - WW'(1)))
                    nxt = ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state)
            ST_IDLE, ST_FILL: in_ready = 1'b1;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_last  = (ocnt == out_w_r - WW'(1));
            end
            default: ;
        endcase
        div_start = (nxt == ST_DIV) && (state != ST_DIV);
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_w_r   <= WW'(MAX_W);
            out_w_r  <= WW'(MAX_W);
            fill_cnt <= '0;
            ocnt     <= '0;
            acc      <= '0;
        end else begin
            if (cfg_ok && width_ok && (cfg_addr == CFG_AW'(ADDR_IN)))
                in_w_r <= cfg_wdata[WW-1:0];
            if (cfg_ok && width_ok && (cfg_addr == CFG_AW'(ADDR_OUT)))
                out_w_r <= cfg_wdata[WW-1:0];
            unique case (state)
                ST_IDLE:
                    if (in_valid && in_sol)
                        fill_cnt <= WW'(1);
                ST_FILL:
                    if (in_valid)
                        fill_cnt <= fill_cnt + WW'(1);
                ST_DIV: begin
                    acc  <= '0;
                    ocnt <= '0;
                end
                ST_EMIT:
                    if (out_ready) begin
                        acc  <= acc + ACC_W'(step);
                        ocnt <= ocnt + WW'(1);
                    end
                default: ;
            endcase
        end
    end

    // ---------------- line buffer ----------------
    logic             lb_we;
    logic [IDX_W-1:0] lb_idx;

    assign lb_we  = in_valid && ((state == ST_FILL) || ((state == ST_IDLE) && in_sol));
    assign lb_idx = (state == ST_IDLE) ? '0 : fill_cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (lb_we)
            lbuf[lb_idx] <= in_data;
    end

    for (genvar g = 0; g < MAX_W; g++) begin : g_pack
        assign line_vec[g*PIX_W +: PIX_W] = lbuf[g];
    end

    // ---------------- step divider ----------------
    hs_div #(.NUM_W(NUM_W), .DEN_W(WW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   ({in_w_r, {FRAC_W{1'b0}}}),
        .den   (out_w_r),
        .quot  (step),
        .done  (div_done)
    );

    // ---------------- coefficients and filter ----------------
    assign phase = acc[FRAC_W-1 -: PH_W];
    assign base  = acc[ACC_W-1:FRAC_W];

    hs_coef_bank #(
        .PHASES(PHASES), .TAPS(TAPS), .TAP_W(TAP_W), .NORM_SH(NORM_SH)
    ) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (coef_we),
        .wr_idx   (cfg_addr[WI_W-1:0]),
        .wr_word  (cfg_wdata),
        .commit   (commit),
        .rd_phase (phase),
        .rd_taps  (taps)
    );

    hs_fir #(
        .PIX_W(PIX_W), .MAX_W(MAX_W), .TAPS(TAPS), .TAP_W(TAP_W),
        .NORM_SH(NORM_SH), .BASE_W(BASE_W)
    ) u_fir (
        .line_vec (line_vec),
        .in_w     (in_w_r),
        .base     (base),
        .taps     (taps),
        .pix      (out_data)
    );

    // ---------------- assertions ----------------
    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
    AST_STREAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R9
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (base < BASE_W'(in_w_r))); // R3
    AST_WIDTH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(in_w_r) && $stable(out_w_r))); // R11
endmodule

// File: tb/sim_hscale_top.sv
module sim_hscale_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sol = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    always #10 clk = ~clk;

    hscale_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_sol(in_sol), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int total = 0;
    int bad   = 0;
    int stage_t [32][8];
    int live_t  [32][8];
    int line    [64];
    int m_in = 64;
    int m_out = 64;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = 32'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_widths(input int iw, input int ow);
        wr(64, iw); wr(65, ow);
        m_in = iw; m_out = ow;
    endtask

    // staging table: interpolating taps with symmetric negative side lobes
    task automatic load_table();
        for (int p = 0; p < 32; p++) begin
            int m;
            int w0;
            int w1;
            m = p % 4;
            for (int k = 0; k < 8; k++) stage_t[p][k] = 0;
            stage_t[p][2] = -4 * m;
            stage_t[p][3] = 64 - 2 * p + 8 * m;
            stage_t[p][4] = 2 * p;
            stage_t[p][5] = -4 * m;
            w0 = 0; w1 = 0;
            for (int k = 0; k < 4; k++) begin
                w0 = w0 | ((stage_t[p][k] & 255) << (8 * k));
                w1 = w1 | ((stage_t[p][k+4] & 255) << (8 * k));
            end
            wr(2 * p, w0);
            wr(2 * p + 1, w1);
        end
    endtask

    task automatic commit_table();
        wr(66, 1);
        for (int p = 0; p < 32; p++)
            for (int k = 0; k < 8; k++) live_t[p][k] = stage_t[p][k];
    endtask

    function automatic int pat(input int seed, input int i);
        case (seed % 4)
            0: return (i * 53 + 17) % 256;
            1: return (i % 2) ? 255 : 0;
            2: return (i * 20) % 256;
            default: return (i * i * 7 + seed) % 256;
        endcase
    endfunction

    function automatic int model_pix(input int iw, input int ow, input int j);
        int step;
        int pos;
        int b;
        int ph;
        int acc;
        step = (iw << 16) / ow;
        pos  = j * step;
        b    = pos >> 16;
        ph   = (pos >> 11) & 31;
        acc  = 0;
        for (int k = 0; k < 8; k++) begin
            int s;
            s = b + k - 3;
            if (s < 0) s = 0;
            if (s > iw - 1) s = iw - 1;
            acc = acc + line[s] * live_t[ph][k];
        end
        acc = (acc + 32) >>> 6;
        if (acc < 0) acc = 0;
        if (acc > 255) acc = 255;
        return acc;
    endfunction

    // send a line (optionally junk first, optionally mid-line writes), then collect
    task automatic run_line(input int seed, input bit junk, input bit bp,
                            input bit midw, input bit ident_chk);
        int i;
        int k;
        int cyc;
        for (int n = 0; n < m_in; n++) line[n] = pat(seed, n);
        if (junk) begin
            for (int n = 0; n < 2; n++) begin
                @(negedge clk);
                in_valid = 1'b1; in_sol = 1'b0; in_data = 8'hA5;
            end
        end
        i = 0;
        while (i < m_in) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (midw && (i == 1 || i == 2) && !cfg_we && in_valid) begin
                in_valid = 1'b0;
                cfg_we = 1'b1;
                cfg_addr  = (i == 1) ? 7'd0 : 7'd65;
                cfg_wdata = (i == 1) ? 32'h7f7f7f7f : 32'd2;
            end else begin
                in_valid = 1'b1; in_sol = (i == 0); in_data = 8'(line[i]);
                i++;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0; in_sol = 1'b0;
        #1 chk(in_ready == 1'b0, "R8 in_ready low after line", int'(in_ready), 0);
        k = 0; cyc = 0;
        while (k < m_out && cyc < 4000) begin
            @(negedge clk);
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (out_valid && out_ready) begin
                int e;
                e = model_pix(m_in, m_out, k);
                if (ident_chk)
                    chk(int'(out_data) == line[k], "R1 identity table", int'(out_data), line[k]);
                else
                    chk(int'(out_data) == e, "R4 R5 filtered sample", int'(out_data), e);
                chk(out_last == (k == m_out - 1), "R9 out_last", int'(out_last), int'(k == m_out - 1));
                k++;
            end
            cyc++;
        end
        chk(k == m_out, "R9 output count", k, m_out);
        @(negedge clk);
        out_ready = 1'b0;
        #1 chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 line closed",
               int'(out_valid), 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int iws [7] = '{1, 2, 3, 4, 7, 8, 13};
        int ows [7] = '{1, 2, 3, 5, 8, 11, 16};
        for (int p = 0; p < 32; p++)
            for (int k = 0; k < 8; k++) begin
                live_t[p][k] = (k == 3) ? 64 : 0;
                stage_t[p][k] = live_t[p][k];
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);

        // R1: default widths 64->64 with identity table
        run_line(0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R3: identity table, upscale 5->9 gives nearest-lower samples
        set_widths(5, 9);
        run_line(3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R6: staged but uncommitted table has no effect
        load_table();
        run_line(0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R2 R3 R4 R5 R10: committed table, sweep of width pairs
        commit_table();
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++) begin
                set_widths(iws[a], ows[b]);
                run_line(a + b, 1'b0, ((a + b) % 2) == 1, 1'b0, 1'b0);
            end

        // large ratios both ways
        set_widths(64, 3);
        run_line(1, 1'b0, 1'b1, 1'b0, 1'b0);
        set_widths(2, 64);
        run_line(2, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: out-of-range width values are ignored
        set_widths(6, 7);
        wr(65, 0);
        wr(65, 65);
        wr(64, 0);
        run_line(1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8: non-start samples in idle are dropped
        set_widths(4, 6);
        run_line(3, 1'b1, 1'b0, 1'b0, 1'b0);

        // R11: writes during a line are ignored (coef word and width)
        set_widths(5, 4);
        run_line(2, 1'b0, 1'b0, 1'b1, 1'b0);
        commit_table();
        run_line(1, 1'b0, 1'b1, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule